// File: doc/BRIEF.md
# Parallel Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous byte-wide flash bus. A client hands it one request at a time through a valid/ready handshake: read a byte, program a byte, or erase the whole chip. For program and erase, the block first plays out the multi-write unlock and command sequence that the flash device expects. Each write strobe is framed so that the chip enable falls before the write enable, and the address and data stay put for the whole strobe.

Once the command is in, the block does not wait a fixed time. It keeps reading the device and judges completion from the status bits in the returned byte, using one of two methods chosen per request. In toggle mode it compares bit 6 across two back-to-back reads. In data-poll mode it checks that bit 7 matches the true value. It then pulses done, or it pulses timeout when a configurable number of reads passes without completion. The write low time, the recovery time and the read access time are parameters counted in clock cycles.

Top module: `fpgm_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are all 1, and `resp_done` and `resp_timeout` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 up to and including the cycle of `resp_done` or `resp_timeout`, and it returns to 1 in the following cycle. `req_valid` is ignored while `req_ready` is 0.
- R3: `req_op` = 2'b01 (program) issues exactly four bus writes, in this order: 0xAA to address 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555, then `req_wdata` to `req_addr`.
- R4: `req_op` = 2'b10 (erase) issues exactly six bus writes, in this order: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555.
- R5: In every write, `fl_we_n` is low only while `fl_ce_n` is low and `fl_oe_n` is high. It stays low for exactly WE_LO cycles, with `fl_addr` and `fl_dout` stable and `fl_dout_en` high. Between bus cycles `fl_ce_n` is high for at least WE_HI cycles.
- R6: In every read, `fl_oe_n` is low only with `fl_ce_n` low and `fl_we_n` high. It stays low for exactly RD_DLY cycles, and `fl_din` is sampled in the last of them.
- R7: With `req_mode` = 0 (toggle), polling reads of `req_addr` end with done when two successive reads return the same bit 6.
- R8: With `req_mode` = 1 (data poll), polling ends with done on the first read whose bit 7 equals bit 7 of the written data. For erase, the expected bit 7 is 1.
- R9: When `cfg_poll_limit` polling reads pass without completion, `resp_timeout` pulses and the block returns to idle. A limit of 0 behaves as 1.
- R10: `req_op` = 2'b00 (or 2'b11) performs one read of `req_addr` and reports done. `resp_rdata` holds the byte read.
- R11: `resp_done` and `resp_timeout` are one-cycle pulses that are never high together. `resp_rdata` holds the value of the last read of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 00/11 read, 01 program, 10 erase |
| req_mode | input | 1 | Completion method: 0 toggle bit, 1 data poll |
| req_addr | input | AW | Target byte address |
| req_wdata | input | 8 | Byte to program |
| cfg_poll_limit | input | PW | Maximum polling reads (0 acts as 1) |
| resp_done | output | 1 | Request finished successfully (pulse) |
| resp_timeout | output | 1 | Polling limit reached (pulse) |
| resp_rdata | output | 8 | Last byte read from the device |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | 8 | Write data toward the flash |
| fl_dout_en | output | 1 | Drive enable for `fl_dout` |
| fl_din | input | 8 | Read data from the flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
A behavioural flash model answers the strobes. It returns the busy pattern (inverted bit 7, flipping bit 6) for a chosen number of reads after a command, or forever when it is set to hang. Program and erase are each tried in both completion modes, with different busy lengths. This separates a wrong sequence, which shows up in the logged write list, from a wrong completion rule, which shows up in the number of polling reads and the final byte. Data-poll cases with the limit one above and exactly at the busy length, a hung device in toggle mode, and a limit of zero pin down the boundary of the timeout count. Plain reads before and after an erase confirm that the read path returns the stored byte.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

    localparam logic [15:0] UNLOCK_A = 16'h5555;
    localparam logic [15:0] UNLOCK_B = 16'h2AAA;

    localparam logic [1:0] OP_READ  = 2'b00;
    localparam logic [1:0] OP_PROG  = 2'b01;
    localparam logic [1:0] OP_ERASE = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE, PH_SETUP, PH_ACT, PH_REC
    } phase_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WLAUNCH, ST_WWAIT, ST_RLAUNCH, ST_RWAIT, ST_FIN
    } state_t;

    typedef struct packed {
        logic        use_tgt;
        logic [15:0] ua;
        logic [7:0]  d;
    } step_t;

    function automatic logic [2:0] seq_last(input logic [1:0] op);
        return (op == OP_ERASE) ? 3'd5 : 3'd3;
    endfunction

    function automatic step_t seq_step(input logic [1:0] op,
                                       input logic [2:0] idx,
                                       input logic [7:0] wd);
        step_t s;
        s.use_tgt = 1'b0;
        s.ua      = UNLOCK_A;
        s.d       = 8'hAA;
        case (idx)
            3'd0: ;
            3'd1, 3'd4: begin s.ua = UNLOCK_B; s.d = 8'h55; end
            3'd2: s.d = (op == OP_ERASE) ? 8'h80 : 8'hA0;
            3'd3: if (op != OP_ERASE) begin s.use_tgt = 1'b1; s.d = wd; end
            default: s.d = 8'h10;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fpgm_bus_cycle.sv
module fpgm_bus_cycle
    import fpgm_pkg::*;
#(
    parameter int AW     = 20,
    parameter int WE_LO  = 2,
    parameter int WE_HI  = 1,
    parameter int RD_DLY = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          is_wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          cyc_done,
    output logic [7:0]    rdata,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dout,
    output logic          fl_dout_en,
    input  logic [7:0]    fl_din,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int MAXL = (WE_LO > WE_HI) ? ((WE_LO > RD_DLY) ? WE_LO : RD_DLY)
                                          : ((WE_HI > RD_DLY) ? WE_HI : RD_DLY);
    localparam int CW = $clog2(MAXL + 1);
    localparam logic [CW-1:0] LAST_W   = CW'(WE_LO - 1);
    localparam logic [CW-1:0] LAST_R   = CW'(RD_DLY - 1);
    localparam logic [CW-1:0] LAST_REC = CW'(WE_HI - 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic [CW-1:0] act_last;

    assign act_last = wr_q ? LAST_W : LAST_R;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            wr_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            rdata  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase  <= PH_SETUP;
                    wr_q   <= is_wr;
                    addr_q <= addr;
                    data_q <= wdata;
                    cnt    <= '0;
                end
                PH_SETUP: phase <= PH_ACT;
                PH_ACT: begin
                    if (cnt == act_last) begin
                        if (!wr_q) rdata <= fl_din;
                        cnt   <= '0;
                        phase <= PH_REC;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (cnt == LAST_REC) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign cyc_done   = (phase == PH_REC) && (cnt == LAST_REC);
    assign fl_ce_n    = !((phase == PH_SETUP) || (phase == PH_ACT));
    assign fl_we_n    = !((phase == PH_ACT) && wr_q);
    assign fl_oe_n    = !((phase == PH_ACT) && !wr_q);
    assign fl_dout_en = wr_q && (phase != PH_IDLE);
    assign fl_addr    = addr_q;
    assign fl_dout    = data_q;

endmodule

// File: rtl/fpgm_poll_eval.sv
module fpgm_poll_eval (
    input  logic mode,
    input  logic have_prev,
    input  logic prev_b6,
    input  logic rd_b6,
    input  logic rd_b7,
    input  logic exp_b7,
    output logic complete
);
    always_comb begin
        if (mode) complete = (rd_b7 == exp_b7);
        else      complete = have_prev && (rd_b6 == prev_b6);
    end
endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
    import fpgm_pkg::*;
#(
    parameter int AW     = 20,
    parameter int PW     = 16,
    parameter int WE_LO  = 2,
    parameter int WE_HI  = 1,
    parameter int RD_DLY = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic          req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_wdata,
    input  logic [PW-1:0] cfg_poll_limit,
    output logic          resp_done,
    output logic          resp_timeout,
    output logic [7:0]    resp_rdata,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dout,
    output logic          fl_dout_en,
    input  logic [7:0]    fl_din,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    state_t        state;
    logic [1:0]    op_q;
    logic          mode_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    wdata_q;
    logic [PW-1:0] lim_q;
    logic [PW-1:0] poll_cnt;
    logic [2:0]    step_q;
    logic          have_prev, prev_b6;

    step_t         step;
    logic [AW-1:0] step_addr;
    logic          cyc_start, cyc_done;
    logic [7:0]    cyc_rdata;
    logic          is_rdop, complete, exp_b7, lim_hit;

    assign step      = seq_step(op_q, step_q, wdata_q);
    assign step_addr = step.use_tgt ? addr_q : {{(AW-16){1'b0}}, step.ua};
    assign cyc_start = (state == ST_WLAUNCH) || (state == ST_RLAUNCH);
    assign is_rdop   = (op_q == OP_READ) || (op_q == 2'b11);
    assign exp_b7    = (op_q == OP_ERASE) ? 1'b1 : wdata_q[7];
    assign lim_hit   = ({1'b0, poll_cnt} + 1'b1) >= {1'b0, lim_q};
    assign req_ready = (state == ST_IDLE);

    fpgm_bus_cycle #(.AW(AW), .WE_LO(WE_LO), .WE_HI(WE_HI), .RD_DLY(RD_DLY)) bus_i (
        .clk(clk), .rst(rst),
        .start(cyc_start), .is_wr(state == ST_WLAUNCH),
        .addr((state == ST_WLAUNCH) ? step_addr : addr_q), .wdata(step.d),
        .cyc_done(cyc_done), .rdata(cyc_rdata),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en),
        .fl_din(fl_din), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    fpgm_poll_eval eval_i (
        .mode(mode_q), .have_prev(have_prev), .prev_b6(prev_b6),
        .rd_b6(cyc_rdata[6]), .rd_b7(cyc_rdata[7]), .exp_b7(exp_b7),
        .complete(complete)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            op_q         <= OP_READ;
            mode_q       <= 1'b0;
            addr_q       <= '0;
            wdata_q      <= '0;
            lim_q        <= '0;
            poll_cnt     <= '0;
            step_q       <= '0;
            have_prev    <= 1'b0;
            prev_b6      <= 1'b0;
            resp_done    <= 1'b0;
            resp_timeout <= 1'b0;
            resp_rdata   <= '0;
        end else begin
            resp_done    <= 1'b0;
            resp_timeout <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    op_q      <= req_op;
                    mode_q    <= req_mode;
                    addr_q    <= req_addr;
                    wdata_q   <= req_wdata;
                    lim_q     <= (cfg_poll_limit == '0) ? PW'(1) : cfg_poll_limit;
                    step_q    <= '0;
                    poll_cnt  <= '0;
                    have_prev <= 1'b0;
                    state     <= ((req_op == OP_PROG) || (req_op == OP_ERASE))
                                 ? ST_WLAUNCH : ST_RLAUNCH;
                end
                ST_WLAUNCH: state <= ST_WWAIT;
                ST_WWAIT: if (cyc_done) begin
                    if (step_q == seq_last(op_q)) state <= ST_RLAUNCH;
                    else begin
                        step_q <= step_q + 3'd1;
                        state  <= ST_WLAUNCH;
                    end
                end
                ST_RLAUNCH: state <= ST_RWAIT;
                ST_RWAIT: if (cyc_done) begin
                    resp_rdata <= cyc_rdata;
                    have_prev  <= 1'b1;
                    prev_b6    <= cyc_rdata[6];
                    if (is_rdop || complete) begin
                        resp_done <= 1'b1;
                        state     <= ST_FIN;
                    end else if (lim_hit) begin
                        resp_timeout <= 1'b1;
                        state        <= ST_FIN;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        state    <= ST_RLAUNCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fpgm_seq_chk.sv
module fpgm_seq_chk #(
    parameter int AW    = 20,
    parameter int WE_LO = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          resp_done,
    input logic          resp_timeout,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_dout,
    input logic          fl_dout_en,
    input logic          fl_ce_n,
    input logic          fl_we_n,
    input logic          fl_oe_n
);
    localparam logic [7:0] LO_W = 8'(WE_LO);
    logic [7:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst)           lo_cnt <= '0;
        else if (!fl_we_n) lo_cnt <= lo_cnt + 8'd1;
        else               lo_cnt <= '0;
    end

    assert_we_framed_R5: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dout_en));

    assert_we_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

    assert_we_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (lo_cnt == LO_W));

    assert_read_framed_R6: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (fl_we_n && !fl_ce_n));

    assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !fl_ce_n |-> !req_ready);

    assert_ready_after_R2: assert property (@(posedge clk) disable iff (rst)
        (resp_done || resp_timeout) |=> req_ready);

    assert_resp_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(resp_done && resp_timeout));

    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (resp_done || resp_timeout) |=> !(resp_done || resp_timeout));

endmodule

bind fpgm_seq fpgm_seq_chk #(.AW(AW), .WE_LO(WE_LO)) chk_i (
    .clk(clk), .rst(rst), .req_ready(req_ready),
    .resp_done(resp_done), .resp_timeout(resp_timeout),
    .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
);

// File: tb/fpgm_seq_tb.sv
module fpgm_seq_tb_top;
    localparam int AW = 20, PW = 16, WE_LO = 3, WE_HI = 2, RD_DLY = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_ready, req_mode = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [PW-1:0] cfg_poll_limit = '0;
    logic resp_done, resp_timeout;
    logic [7:0] resp_rdata;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_dout, fl_din;
    logic fl_dout_en, fl_ce_n, fl_we_n, fl_oe_n;

    always #2 clk = ~clk;

    fpgm_seq #(.AW(AW), .PW(PW), .WE_LO(WE_LO), .WE_HI(WE_HI), .RD_DLY(RD_DLY)) dut_i (.*);

    int errors = 0, checks = 0, cyc = 0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0] mem [int];
    logic [AW-1:0] log_a [$];
    logic [7:0] log_d [$];
    logic [7:0] rd_val = 8'hFF, last_d = 8'hFF;
    logic tog = 1'b0, armed = 1'b0, stuck_cfg = 1'b0;
    int busy_cfg = 0, busy_left = 0, rd_n = 0;
    assign fl_din = rd_val;

    always @(posedge fl_we_n) if (!rst) begin
        log_a.push_back(fl_addr);
        log_d.push_back(fl_dout);
        if (armed) begin
            mem[int'(fl_addr)] = (mem.exists(int'(fl_addr)) ? mem[int'(fl_addr)] : 8'hFF) & fl_dout;
            last_d = fl_dout; busy_left = busy_cfg; armed = 1'b0;
        end else if (fl_addr == 20'h05555 && fl_dout == 8'hA0) armed = 1'b1;
        else if (fl_addr == 20'h05555 && fl_dout == 8'h10) begin
            mem.delete(); last_d = 8'hFF; busy_left = busy_cfg;
        end
    end

    always @(negedge fl_oe_n) if (!rst) begin
        rd_n++;
        if (stuck_cfg || busy_left > 0) begin
            if (busy_left > 0) busy_left--;
            tog = !tog;
            rd_val = {~last_d[7], tog, last_d[5:0]};
        end else rd_val = mem.exists(int'(fl_addr)) ? mem[int'(fl_addr)] : 8'hFF;
    end

    // ---------------- strobe width monitor ----------------
    int we_run = 0, we_min = 99, we_max = 0, oe_run = 0, oe_min = 99, oe_max = 0;
    int ce_hi = 0, gap_min = 99;
    logic ce_seen = 1'b0;
    always @(negedge clk) if (!rst) begin
        if (!fl_we_n) we_run++;
        else if (we_run != 0) begin
            if (we_run < we_min) we_min = we_run;
            if (we_run > we_max) we_max = we_run;
            we_run = 0;
        end
        if (!fl_oe_n) oe_run++;
        else if (oe_run != 0) begin
            if (oe_run < oe_min) oe_min = oe_run;
            if (oe_run > oe_max) oe_max = oe_run;
            oe_run = 0;
        end
        if (fl_ce_n) ce_hi++;
        else begin
            if (ce_seen && ce_hi != 0 && ce_hi < gap_min) gap_min = ce_hi;
            ce_hi = 0; ce_seen = 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- vectors ----------------
    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] addr;
        logic [7:0]  data;
        logic        mode;
        logic [3:0]  busy;
        logic        stuck;
        logic [7:0]  lim;
        logic        exp_to;
        logic [7:0]  exp_rd;
        logic [7:0]  exp_nrd;   // 0 = not checked
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 20'h12345, 8'h5A, 1'b0, 4'd3, 1'b0, 8'd20, 1'b0, 8'h5A, 8'd0},
        '{2'b00, 20'h12345, 8'h00, 1'b0, 4'd0, 1'b0, 8'd20, 1'b0, 8'h5A, 8'd1},
        '{2'b01, 20'h00010, 8'hC3, 1'b1, 4'd4, 1'b0, 8'd20, 1'b0, 8'hC3, 8'd5},
        '{2'b10, 20'h00000, 8'h00, 1'b0, 4'd5, 1'b0, 8'd20, 1'b0, 8'hFF, 8'd0},
        '{2'b10, 20'h00000, 8'h00, 1'b1, 4'd2, 1'b0, 8'd20, 1'b0, 8'hFF, 8'd3},
        '{2'b01, 20'h0ABCD, 8'h80, 1'b1, 4'd3, 1'b0, 8'd4,  1'b0, 8'h80, 8'd4},
        '{2'b01, 20'h0BCDE, 8'h81, 1'b1, 4'd3, 1'b0, 8'd3,  1'b1, 8'h00, 8'd3},
        '{2'b01, 20'h01111, 8'h3C, 1'b0, 4'd0, 1'b1, 8'd5,  1'b1, 8'h00, 8'd5},
        '{2'b11, 20'h00010, 8'h00, 1'b0, 4'd0, 1'b0, 8'd20, 1'b0, 8'hFF, 8'd1}
    };

    function automatic logic [27:0] exp_wr(input logic [1:0] op, input int i,
                                           input logic [19:0] a, input logic [7:0] d);
        logic [19:0] ea [6] = '{20'h05555, 20'h02AAA, 20'h05555, 20'h05555, 20'h02AAA, 20'h05555};
        logic [7:0]  ed [6] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55, 8'h10};
        if (op == 2'b01) begin
            if (i == 2) return {20'h05555, 8'hA0};
            if (i == 3) return {a, d};
        end
        return {ea[i], ed[i]};
    endfunction

    task automatic run(input vec_t v, input string tag);
        logic fin_done, fin_to;
        int n, nwr, bad;
        @(negedge clk);
        log_a.delete(); log_d.delete(); rd_n = 0;
        busy_cfg = int'(v.busy); stuck_cfg = v.stuck;
        req_op = v.op; req_addr = v.addr; req_wdata = v.data; req_mode = v.mode;
        cfg_poll_limit = PW'(v.lim); req_valid = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, {tag, " R2 ready low after accept"}, req_ready, 0);
        req_op = 2'b00; req_addr = 20'h00010;   // held valid while busy: must be ignored
        fin_done = 1'b0; fin_to = 1'b0;
        for (n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (resp_done || resp_timeout) begin
                fin_done = resp_done; fin_to = resp_timeout; break;
            end
        end
        req_valid = 1'b0;
        chk(fin_to == v.exp_to && fin_done == !v.exp_to,
            {tag, (v.exp_to ? " R9 timeout" : " R7/R8/R10 done")},
            {fin_done, fin_to}, {!v.exp_to, v.exp_to});
        if (!v.exp_to)
            chk(resp_rdata == v.exp_rd, {tag, " R11 rdata"}, resp_rdata, v.exp_rd);
        if (v.exp_nrd != 0)
            chk(rd_n == int'(v.exp_nrd), {tag, " R8/R9 poll reads"}, rd_n, v.exp_nrd);
        nwr = (v.op == 2'b01) ? 4 : (v.op == 2'b10) ? 6 : 0;
        chk(log_a.size() == nwr, {tag, (v.op == 2'b10) ? " R4 write count" : " R3 write count"},
            log_a.size(), nwr);
        bad = 0;
        for (int i = 0; i < nwr && i < log_a.size(); i++)
            if ({log_a[i], log_d[i]} != exp_wr(v.op, i, v.addr, v.data)) bad++;
        chk(bad == 0, {tag, (v.op == 2'b10) ? " R4 write order" : " R3 write order"}, bad, 0);
        @(negedge clk);
        chk(req_ready && !resp_done && !resp_timeout, {tag, " R11 pulse/R2 ready back"},
            {req_ready, resp_done, resp_timeout}, 3'b100);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !resp_done && !resp_timeout,
            "R1 reset state", {req_ready, fl_ce_n, fl_we_n, fl_oe_n, resp_done, resp_timeout},
            6'b111100);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n, "R1 after reset",
            {req_ready, fl_ce_n, fl_we_n, fl_oe_n}, 4'b1111);

        for (int k = 0; k < NV; k++) run(VECS[k], $sformatf("vec%0d", k));

        // limit of zero acts as one read
        run('{2'b01, 20'h02222, 8'h11, 1'b1, 4'd0, 1'b1, 8'd0, 1'b1, 8'h00, 8'd1}, "lim0 R9");

        chk(we_min == WE_LO && we_max == WE_LO, "R5 we low width", we_max, WE_LO);
        chk(oe_min == RD_DLY && oe_max == RD_DLY, "R6 oe low width", oe_max, RD_DLY);
        chk(gap_min >= WE_HI, "R5 recovery gap", gap_min, WE_HI);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule